// File: doc/BRIEF.md
# Paged serial configuration memory reader

This block is the read side of a bit-serial configuration store that feeds an FPGA one bitstream bit per clock. A bit array sits behind an address counter. A single active-low reset line, which is also the output enable, puts the counter back at its starting point. An active-low chip enable lets the counter step and lets the data line be driven. Each enabled clock presents the next stored bit, most significant bit of each byte first. A cascade output goes low once the last bit has been read, so that the chip enable of a following device in a daisy chain can be tied to it.

The array can be used as one space or as four equal quarters. When paging is on, the page-select pins choose which quarter is read. Reading starts at the bottom of that quarter and stops at its top. The paging choice is captured while reset is held. A serial-enable input selects programming mode when low. In that mode the paging pins are ignored, chip enable neither starts nor stops the reader, and the counter holds. A byte-wide write port loads the array.

The control is a four-state machine. RD_RESET is entered and held while the reset line is low. RD_PAUSE is entered when chip enable is high and the read is not finished. RD_SHIFT means the last enabled clock advanced the counter. RD_DONE means the end bit has been read, and only a reset leaves it. From RD_RESET, RD_PAUSE or RD_SHIFT, an enabled clock moves to RD_DONE if the counter is at its end address and to RD_SHIFT otherwise. From any of those three states, a clock with chip enable high moves to RD_PAUSE. Any state goes to RD_RESET on a clock with reset low. While programming mode is selected, the state holds.

Top module: `cfg_serial_reader`

## Requirements
- R1: With `oe_rstn` low at a rising clock, the counter loads the start address. This is 0 when paging is off, and `page_sel` × DEPTH_BITS/4 when paging is on. After reset is released, the first bit shown is the bit at that address.
- R2: Bit address a is bit 7−(a mod 8) of byte a/8, so each byte goes out MSB first. `data_out` shows the bit at the counter combinationally. Each enabled rising clock moves the counter up by one.
- R3: `data_oe` is high only when `oe_rstn` is high, `ce_n` is low, `ser_en` is high and the read is not finished. While `data_oe` is low, `data_out` reads 0.
- R4: While `ce_n` is high, the counter holds and the read continues from the same bit afterwards. `standby` is high in the cycle after a clock edge that sampled `ce_n` high with `ser_en` high.
- R5: When `page_en` is high, `page_sel` (0..3) selects quarter q, which spans addresses q·DEPTH_BITS/4 to (q+1)·DEPTH_BITS/4−1. The page choice is captured at reset, and later changes to `page_en` or `page_sel` have no effect until the next reset.
- R6: With paging off, reading runs from address 0 to DEPTH_BITS−1, which is the whole array.
- R7: After the clock that reads the end address, `ceo_n` goes low with `ce_n` low and `data_oe` goes low. The counter holds at the end address and never wraps.
- R8: Once the read is finished and while `oe_rstn` is high, `ceo_n` follows `ce_n`. When `oe_rstn` goes low, `ceo_n` goes high at once and stays high until a complete read finishes again.
- R9: With `ser_en` low, `data_oe` and `standby` are low, the counter holds whatever the level of `ce_n`, and `page_en`/`page_sel` are treated as paging off at reset.
- R10: A high `wr_en` at a rising clock stores `wr_data` into byte `wr_addr`, and that byte is read back in bit order as set out in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read and write clock |
| oe_rstn | input | 1 | Low: synchronous counter reset; high: output enable |
| ce_n | input | 1 | Active-low chip enable |
| ser_en | input | 1 | High: read mode; low: programming mode |
| page_en | input | 1 | Enables four-quarter paging |
| page_sel | input | 2 | Quarter chosen when paging is on |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | $clog2(DEPTH_BITS)-3 | Byte address for writes |
| wr_data | input | 8 | Byte to store |
| data_out | output | 1 | Serial bitstream bit |
| data_oe | output | 1 | Data driver enable (low means high impedance) |
| ceo_n | output | 1 | Active-low cascade enable for the next device |
| standby | output | 1 | Registered low-power standby flag |

## Verification
A counter loaded with the wrong start shows up on the first bit after reset, because the data bit is combinational from the counter. A counter that skips or stalls puts a wrong bit on `data_out` in the very cycle it happens. An end compare that is off by one moves the fall of `ceo_n` and of `data_oe` by one clock, and a wrap shows as a driven bit after the cascade output has fallen. A lost sticky state makes `ceo_n` fall after a reset without a full read. Reading every quarter and the whole array bit for bit exposes each of these within one clock of the fault.

// File: rtl/cfg_rd_pkg.sv
package cfg_rd_pkg;

    typedef enum logic [1:0] {
        RD_RESET = 2'd0,
        RD_PAUSE = 2'd1,
        RD_SHIFT = 2'd2,
        RD_DONE  = 2'd3
    } rd_state_e;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned PAGE_W = 2;

endpackage

// File: rtl/cfg_rd_bitmem.sv
module cfg_rd_bitmem
    import cfg_rd_pkg::*;
#(
    parameter int unsigned DEPTH_BITS = 256,
    localparam int unsigned AW    = $clog2(DEPTH_BITS),
    localparam int unsigned BAW   = AW - 3,
    localparam int unsigned BYTES = DEPTH_BITS / BYTE_W
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [BAW-1:0]    wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic              rd_bit
);

    logic [BYTE_W-1:0] store [BYTES];
    logic [BYTE_W-1:0] cur_byte;
    logic [2:0]        bit_pos;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[wr_addr] <= wr_data;
        end
    end

    // Bits leave each byte starting at the most significant one.
    always_comb begin
        cur_byte = store[rd_addr[AW-1:3]];
        bit_pos  = 3'd7 - rd_addr[2:0];
        rd_bit   = cur_byte[bit_pos];
    end

endmodule

// File: rtl/cfg_rd_addr_ctr.sv
module cfg_rd_addr_ctr
    import cfg_rd_pkg::*;
#(
    parameter int unsigned DEPTH_BITS = 256,
    localparam int unsigned AW = $clog2(DEPTH_BITS),
    localparam int unsigned QW = AW - PAGE_W
) (
    input  logic              clk,
    input  logic              load,
    input  logic              adv,
    input  logic              page_on,
    input  logic [PAGE_W-1:0] page_sel,
    output logic [AW-1:0]     rd_addr,
    output logic [AW-1:0]     end_addr,
    output logic              at_end
);

    logic              page_on_q;
    logic [PAGE_W-1:0] page_q;
    logic [AW-1:0]     start_addr;

    // Start point from the live pins; captured only while load is high.
    always_comb begin
        if (page_on) begin
            start_addr = {page_sel, {QW{1'b0}}};
        end else begin
            start_addr = '0;
        end
    end

    always_comb begin
        if (page_on_q) begin
            end_addr = {page_q, {QW{1'b1}}};
        end else begin
            end_addr = '1;
        end
        at_end = (rd_addr == end_addr);
    end

    always_ff @(posedge clk) begin
        if (load) begin
            rd_addr   <= start_addr;
            page_on_q <= page_on;
            page_q    <= page_sel;
        end else if (adv && !at_end) begin
            rd_addr <= rd_addr + 1'b1;
        end
    end

endmodule

// File: rtl/cfg_rd_fsm.sv
module cfg_rd_fsm
    import cfg_rd_pkg::*;
(
    input  logic      clk,
    input  logic      oe_rstn,
    input  logic      ce_n,
    input  logic      ser_en,
    input  logic      at_end,
    output logic      load,
    output logic      adv,
    output logic      data_oe,
    output logic      ceo_n,
    output logic      standby,
    output rd_state_e state
);

    rd_state_e state_nx;
    logic      go;

    always_comb begin
        go       = oe_rstn && !ce_n && ser_en && (state != RD_DONE);
        state_nx = state;
        if (!oe_rstn) begin
            state_nx = RD_RESET;
        end else if (ser_en) begin
            unique case (state)
                RD_RESET, RD_PAUSE, RD_SHIFT: begin
                    if (ce_n) begin
                        state_nx = RD_PAUSE;
                    end else if (at_end) begin
                        state_nx = RD_DONE;
                    end else begin
                        state_nx = RD_SHIFT;
                    end
                end
                RD_DONE: state_nx = RD_DONE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        state   <= state_nx;
        standby <= ser_en && ce_n;
    end

    always_comb begin
        load    = !oe_rstn;
        adv     = go;
        data_oe = go;
        if ((state == RD_DONE) && oe_rstn) begin
            ceo_n = ce_n;
        end else begin
            ceo_n = 1'b1;
        end
    end

endmodule

// File: rtl/cfg_serial_reader.sv
module cfg_serial_reader
    import cfg_rd_pkg::*;
#(
    parameter int unsigned DEPTH_BITS = 256,
    localparam int unsigned AW  = $clog2(DEPTH_BITS),
    localparam int unsigned BAW = AW - 3
) (
    input  logic           clk,
    input  logic           oe_rstn,
    input  logic           ce_n,
    input  logic           ser_en,
    input  logic           page_en,
    input  logic [1:0]     page_sel,
    input  logic           wr_en,
    input  logic [BAW-1:0] wr_addr,
    input  logic [7:0]     wr_data,
    output logic           data_out,
    output logic           data_oe,
    output logic           ceo_n,
    output logic           standby
);

    logic          load;
    logic          adv;
    logic          at_end;
    logic          rd_bit;
    logic          page_on;
    logic [AW-1:0] rd_addr;
    logic [AW-1:0] end_addr;
    rd_state_e     state;

    // Programming mode masks the paging pins.
    assign page_on  = page_en && ser_en;
    assign data_out = rd_bit && data_oe;

    cfg_rd_fsm u_fsm (
        .clk     (clk),
        .oe_rstn (oe_rstn),
        .ce_n    (ce_n),
        .ser_en  (ser_en),
        .at_end  (at_end),
        .load    (load),
        .adv     (adv),
        .data_oe (data_oe),
        .ceo_n   (ceo_n),
        .standby (standby),
        .state   (state)
    );

    cfg_rd_addr_ctr #(.DEPTH_BITS(DEPTH_BITS)) u_ctr (
        .clk      (clk),
        .load     (load),
        .adv      (adv),
        .page_on  (page_on),
        .page_sel (page_sel),
        .rd_addr  (rd_addr),
        .end_addr (end_addr),
        .at_end   (at_end)
    );

    cfg_rd_bitmem #(.DEPTH_BITS(DEPTH_BITS)) u_mem (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_bit  (rd_bit)
    );

endmodule

// File: rtl/cfg_serial_reader_chk.sv
module cfg_serial_reader_chk #(
    parameter int unsigned AW = 8
) (
    input logic          clk,
    input logic          oe_rstn,
    input logic          ce_n,
    input logic          ser_en,
    input logic          data_oe,
    input logic          ceo_n,
    input logic          standby,
    input logic          at_end,
    input logic [AW-1:0] rd_addr,
    input logic [AW-1:0] end_addr
);

    // R3
    a_r3_drive_gate: assert property (@(posedge clk) disable iff (!oe_rstn)
        data_oe |-> (!ce_n && ser_en));

    // R2
    a_r2_step: assert property (@(posedge clk) disable iff (!oe_rstn)
        (data_oe && !at_end) |=> (rd_addr == $past(rd_addr) + 1'b1));

    // R4, R9
    a_r4_freeze: assert property (@(posedge clk) disable iff (!oe_rstn)
        (ce_n || !ser_en) |=> $stable(rd_addr));

    // R4
    a_r4_standby: assert property (@(posedge clk) disable iff (!oe_rstn)
        (ce_n && ser_en) |=> standby);

    // R7
    a_r7_hold_end: assert property (@(posedge clk) disable iff (!oe_rstn)
        at_end |=> $stable(rd_addr));

    // R7
    a_r7_release: assert property (@(posedge clk) disable iff (!oe_rstn)
        (data_oe && at_end) |=> (!data_oe && (ce_n || !ceo_n)));

    // R7
    a_r7_in_range: assert property (@(posedge clk) disable iff (!oe_rstn)
        rd_addr <= end_addr);

    // R8
    a_r8_ceo_needs_ce: assert property (@(posedge clk) disable iff (!oe_rstn)
        !ceo_n |-> !ce_n);

endmodule

bind cfg_serial_reader cfg_serial_reader_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .oe_rstn  (oe_rstn),
    .ce_n     (ce_n),
    .ser_en   (ser_en),
    .data_oe  (data_oe),
    .ceo_n    (ceo_n),
    .standby  (standby),
    .at_end   (at_end),
    .rd_addr  (rd_addr),
    .end_addr (end_addr)
);

// File: tb/cfg_serial_reader_test.sv
module cfg_serial_reader_test;

    localparam int DEPTH = 256;
    localparam int NBYTE = DEPTH / 8;
    localparam int QTR   = DEPTH / 4;

    logic       clk = 1'b0;
    logic       oe_rstn, ce_n, ser_en, page_en;
    logic [1:0] page_sel;
    logic       wr_en;
    logic [4:0] wr_addr;
    logic [7:0] wr_data;
    logic       data_out, data_oe, ceo_n, standby;

    int checks   = 0;
    int failures = 0;
    logic [7:0] model [NBYTE];

    always #4 clk = ~clk;

    cfg_serial_reader #(.DEPTH_BITS(DEPTH)) uut (
        .clk(clk), .oe_rstn(oe_rstn), .ce_n(ce_n), .ser_en(ser_en),
        .page_en(page_en), .page_sel(page_sel), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .data_out(data_out),
        .data_oe(data_oe), .ceo_n(ceo_n), .standby(standby)
    );

    function automatic logic exp_bit(int a);
        logic [7:0] b;
        b = model[a / 8];
        return b[7 - (a % 8)];
    endfunction

    task automatic check(logic ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic do_reset(logic se, logic pe, logic [1:0] ps);
        @(negedge clk);
        oe_rstn = 1'b0; ce_n = 1'b1; ser_en = se; page_en = pe; page_sel = ps;
        repeat (2) @(negedge clk);
    endtask

    task automatic read_bits(int base, int n, string req);
        for (int i = 0; i < n; i++) begin
            #1;
            check(data_out === exp_bit(base + i) && data_oe === 1'b1 && ceo_n === 1'b1,
                  req, {data_oe, ceo_n, data_out}, {2'b11, exp_bit(base + i)});
            @(negedge clk);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        oe_rstn = 1'b0; ce_n = 1'b1; ser_en = 1'b1; page_en = 1'b0; page_sel = 2'd0;
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        repeat (3) @(negedge clk);
        // R10: preload through the write port
        for (int k = 0; k < NBYTE; k++) begin
            wr_en = 1'b1; wr_addr = 5'(k); wr_data = 8'((k * 37 + 11) & 255);
            model[k] = wr_data;
            @(negedge clk);
        end
        wr_en = 1'b0;
        #1;
        check(data_oe === 1'b0 && ceo_n === 1'b1 && data_out === 1'b0, "R3 reset state",
              {data_oe, ceo_n, data_out}, 3'b010);

        // R1 R5 R6 R7 R8: each quarter, then the whole array
        for (int m = 0; m < 5; m++) begin
            int base;
            int len;
            base = (m < 4) ? m * QTR : 0;
            len  = (m < 4) ? QTR : DEPTH;
            do_reset(1'b1, m < 4, 2'(m));
            oe_rstn = 1'b1; ce_n = 1'b0;
            read_bits(base, len, (m < 4) ? "R5 page read" : "R6 full read");
            #1;
            check(ceo_n === 1'b0 && data_oe === 1'b0, "R7 end reached", {ceo_n, data_oe}, 0);
            repeat (3) step();
            check(ceo_n === 1'b0 && data_oe === 1'b0 && data_out === 1'b0, "R7 hold no wrap",
                  {ceo_n, data_oe}, 0);
            ce_n = 1'b1; #1;
            check(ceo_n === 1'b1, "R8 follow ce high", ceo_n, 1);
            step();
            check(standby === 1'b1, "R4 standby", standby, 1);
            @(negedge clk); ce_n = 1'b0; #1;
            check(ceo_n === 1'b0, "R8 follow ce low", ceo_n, 0);
            @(negedge clk); oe_rstn = 1'b0; #1;
            check(ceo_n === 1'b1, "R8 oe low releases", ceo_n, 1);
            @(negedge clk); @(negedge clk); oe_rstn = 1'b1; ce_n = 1'b1;
            repeat (4) step();
            check(ceo_n === 1'b1 && data_oe === 1'b0, "R8 sticky high", {ceo_n, data_oe}, 2);
        end

        // R4: pause mid-read and resume
        do_reset(1'b1, 1'b0, 2'd0);
        oe_rstn = 1'b1; ce_n = 1'b0;
        read_bits(0, 10, "R2 before pause");
        ce_n = 1'b1;
        repeat (3) step();
        check(data_oe === 1'b0 && standby === 1'b1 && ceo_n === 1'b1, "R4 paused",
              {data_oe, standby, ceo_n}, 3'b011);
        @(negedge clk); ce_n = 1'b0;
        read_bits(10, 6, "R4 resume");

        // R9: programming mode ignores paging and chip enable
        do_reset(1'b0, 1'b1, 2'd2);
        oe_rstn = 1'b1; ce_n = 1'b0; ser_en = 1'b1;
        read_bits(0, 12, "R9 paging ignored");
        ser_en = 1'b0; ce_n = 1'b1;
        repeat (2) step();
        check(data_oe === 1'b0 && standby === 1'b0, "R9 ce high ignored",
              {data_oe, standby}, 0);
        @(negedge clk); ce_n = 1'b0;
        repeat (3) step();
        check(data_oe === 1'b0 && standby === 1'b0, "R9 ce low ignored",
              {data_oe, standby}, 0);
        @(negedge clk); ser_en = 1'b1;
        read_bits(12, 8, "R9 counter held");

        // R5: page captured at reset, later pin changes ignored
        do_reset(1'b1, 1'b1, 2'd1);
        oe_rstn = 1'b1; ce_n = 1'b0;
        read_bits(QTR, 5, "R5 latch start");
        page_sel = 2'd3; page_en = 1'b0;
        read_bits(QTR + 5, QTR - 5, "R5 latch rest");
        #1;
        check(ceo_n === 1'b0, "R5 latched end", ceo_n, 0);

        // R10 R1: overwrite first byte, read it back from page 0
        @(negedge clk);
        oe_rstn = 1'b0; ce_n = 1'b1; page_en = 1'b1; page_sel = 2'd0;
        wr_en = 1'b1; wr_addr = 5'd0; wr_data = 8'hA5; model[0] = 8'hA5;
        @(negedge clk); wr_en = 1'b0;
        @(negedge clk);
        oe_rstn = 1'b1; ce_n = 1'b0;
        read_bits(0, 8, "R10 rewrite R1 start");

        finish_run();
    end

endmodule